// File: doc/BRIEF.md
# Multiplexed External Code-Fetch Bus Controller

This block reads bytes of program code from an external memory over a narrow multiplexed bus. A core hands it a 16-bit code address with a one-clock request. The block splits the address into two parts. The high byte goes out on a dedicated port. The low byte goes out first on a shared bidirectional port, and an address-latch strobe tells an external latch to capture it. The block then releases the shared port and pulls the active-low program-store strobe, so the memory can drive the byte back on the same pins. The byte is returned to the core together with a one-clock done pulse. Instruction fetches and table reads of code space use this bus cycle in the same way, so the block needs no input that tells them apart.

The block runs on the oscillator clock and makes its own CPU clock enable from it. In standard mode one CPU clock is two oscillator periods. In double-speed mode one CPU clock is one oscillator period. Every bus cycle is six CPU clocks long. The mode input is taken only while no cycle is running, so a cycle in flight never changes length.

Top module: `xcode_fetch`

## Requirements
- R1: `cpu_ce` is high on every second oscillator clock in standard mode (the first time two clocks after reset) and on every oscillator clock in double-speed mode (`x2_mode`=1).
- R2: Each bus cycle is 6 CPU clocks long. `psen_n` is low for 3 of them, which is 6 oscillator clocks in standard mode and 3 in double-speed mode.
- R3: `ale` is high during CPU clocks 0 and 1 of a cycle. `ad_oe` is high during CPU clocks 0 to 2, and while it is high `ad_out` carries address bits 7:0. `ale` falls while the address is still driven.
- R4: During CPU clocks 3 to 5, `ad_oe` is low and `psen_n` is low. `ad_oe` and a low `psen_n` never occur in the same clock.
- R5: `a_hi` carries address bits 15:8 for the whole cycle.
- R6: `ad_in` is sampled on the final CPU clock of the cycle. `done` then goes high for exactly one oscillator clock, with the sampled byte on `rdata`.
- R7: While no cycle is running, `ale` is 0, `psen_n` is 1 and `ad_oe` is 0.
- R8: One request that arrives during a cycle is held and starts on the CPU clock right after the current cycle ends. A further request that arrives while one is already held is dropped.
- R9: `x2_mode` is taken only while no cycle is running. A change in the middle of a cycle takes effect after the cycle ends.
- R10: A synchronous high `rst` ends any cycle, drops a held request and leaves all strobes idle after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| x2_mode | input | 1 | 1 selects double-speed mode |
| req | input | 1 | One-clock request for a code byte |
| req_addr | input | 16 | Code address of the request |
| rdata | output | 8 | Fetched byte, valid while `done` is high |
| done | output | 1 | One-clock completion pulse |
| cpu_ce | output | 1 | CPU clock enable |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program store strobe, active low |
| a_hi | output | 8 | Address bits 15:8 |
| ad_out | output | 8 | Low address driven onto the shared port |
| ad_oe | output | 1 | Output enable of the shared port |
| ad_in | input | 8 | Value read from the shared port |

## Verification
Single fetches in standard mode and in double-speed mode show whether each phase lasts the right number of oscillator clocks. Requests issued during a running cycle show whether one request is held and started right away, and whether a third one is dropped. A mode change in the middle of a cycle shows whether the new mode waits until the cycle has ended. A reset in the middle of a cycle, and a memory model that returns a byte depending on the latched address, show the abort path and that the data is sampled after the address has been latched and the port released.

// File: rtl/xcode_fetch.sv
module xcode_fetch #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int CYC       = 6,
  parameter int ALE_CLKS  = 2,
  parameter int ADDR_CLKS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          x2_mode,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic          cpu_ce,
  output logic          ale,
  output logic          psen_n,
  output logic [AW-DW-1:0] a_hi,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in
);
  localparam int PW = $clog2(CYC);
  localparam logic [PW-1:0] LAST = PW'(CYC - 1);

  logic          div_q, mode_q, busy_q, pend_q, done_q;
  logic [PW-1:0] ph_q;
  logic [AW-1:0] cur_q, pend_a;
  logic [DW-1:0] rd_q;

  assign cpu_ce = mode_q | div_q;

  logic last, start;
  assign last  = busy_q && (ph_q == LAST);
  assign start = cpu_ce && pend_q && (!busy_q || last);

  assign ale    = busy_q && (ph_q < PW'(ALE_CLKS));
  assign ad_oe  = busy_q && (ph_q < PW'(ADDR_CLKS));
  assign psen_n = !(busy_q && (ph_q >= PW'(ADDR_CLKS)));
  assign ad_out = cur_q[DW-1:0];
  assign a_hi   = cur_q[AW-1:DW];
  assign rdata  = rd_q;
  assign done   = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= 1'b0;
      mode_q <= 1'b0;
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      ph_q   <= '0;
      cur_q  <= '0;
      pend_a <= '0;
      rd_q   <= '0;
    end else begin
      div_q  <= !div_q;
      done_q <= 1'b0;
      if (!busy_q) mode_q <= x2_mode;

      if (start) pend_q <= req;
      else if (!pend_q) pend_q <= req;
      if (req && (start || !pend_q)) pend_a <= req_addr;

      if (cpu_ce && last) begin
        rd_q   <= ad_in;
        done_q <= 1'b1;
      end

      if (start) begin
        busy_q <= 1'b1;
        ph_q   <= '0;
        cur_q  <= pend_a;
      end else if (cpu_ce && busy_q) begin
        if (last) busy_q <= 1'b0;
        else ph_q <= ph_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xcode_fetch_chk.sv
module xcode_fetch_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic          ale,
  input logic          psen_n,
  input logic          ad_oe,
  input logic [AW-DW-1:0] a_hi
);
  assert_no_contention_R4: assert property (@(posedge clk) disable iff (rst)
    !(ad_oe && !psen_n));

  assert_ale_with_addr_R3: assert property (@(posedge clk) disable iff (rst)
    ale |-> ad_oe);

  assert_ale_fall_hold_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> ad_oe);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_hi_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (!psen_n && $past(!psen_n)) |-> $stable(a_hi));

  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> (!ale && psen_n && !ad_oe && !done));
endmodule

bind xcode_fetch xcode_fetch_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .done(done), .ale(ale),
  .psen_n(psen_n), .ad_oe(ad_oe), .a_hi(a_hi)
);

// File: tb/sim_xcode_fetch.sv
`timescale 1ns/1ps
module sim_xcode_fetch;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x2_mode = 1'b0;
  logic req = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] rdata, ad_out, ad_in, a_hi;
  logic done, cpu_ce, ale, psen_n, ad_oe;

  always #5 clk = !clk;

  xcode_fetch u0 (
    .clk(clk), .rst(rst), .x2_mode(x2_mode), .req(req), .req_addr(req_addr),
    .rdata(rdata), .done(done), .cpu_ce(cpu_ce), .ale(ale), .psen_n(psen_n),
    .a_hi(a_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  logic [7:0] lat = '0;
  always @(posedge clk) if (ale) lat <= ad_out;
  assign ad_in = !psen_n ? mem({a_hi, lat}) : 8'h00;

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  int m_div, m_mode, m_busy, m_ph, m_done;
  logic [15:0] m_cur;
  logic [7:0] m_rd;
  logic [15:0] m_q[$];

  always @(posedge clk) begin
    if (rst) begin
      m_div = 0; m_mode = 0; m_busy = 0; m_ph = 0; m_done = 0;
      m_cur = '0; m_rd = '0; m_q.delete();
    end else begin
      int ce, was_busy;
      bit consumed;
      ce = m_mode | m_div;
      was_busy = m_busy;
      consumed = 0;
      m_done = 0;
      if (ce != 0) begin
        if (m_busy != 0) begin
          if (m_ph == 5) begin
            m_rd = mem(m_cur);
            m_done = 1;
            if (m_q.size() > 0) begin m_cur = m_q.pop_front(); m_ph = 0; consumed = 1; end
            else m_busy = 0;
          end else m_ph++;
        end else if (m_q.size() > 0) begin
          m_cur = m_q.pop_front(); m_busy = 1; m_ph = 0; consumed = 1;
        end
      end
      if (req && m_q.size() == 0) m_q.push_back(req_addr);
      if (was_busy == 0) m_mode = int'(x2_mode);
      m_div = 1 - m_div;
    end
  end

  int psen_cnt = 0;
  bit run = 1'b0;
  always @(negedge clk) if (run) begin
    int xb;
    xb = m_busy;
    chk("R1 R9 cpu_ce", int'(cpu_ce), (m_mode | m_div) != 0);
    chk("R3 ale", int'(ale), xb != 0 && m_ph < 2);
    chk("R3 R4 ad_oe", int'(ad_oe), xb != 0 && m_ph < 3);
    chk("R4 psen_n", int'(psen_n), !(xb != 0 && m_ph >= 3));
    chk("R4 contention", int'(ad_oe && !psen_n), 0);
    if (xb != 0 && m_ph < 3) chk("R3 ad_out", int'(ad_out), int'(m_cur[7:0]));
    if (xb != 0) chk("R5 a_hi", int'(a_hi), int'(m_cur[15:8]));
    if (xb == 0) chk("R7 idle strobes", int'({ale, psen_n, ad_oe}), 3'b010);
    chk("R6 R8 done", int'(done), m_done);
    if (m_done != 0) chk("R6 rdata", int'(rdata), int'(m_rd));
    if (rst) psen_cnt = 0;
    else if (!psen_n) psen_cnt++;
    else if (psen_cnt > 0) begin
      chk("R2 psen low length", psen_cnt, m_mode != 0 ? 3 : 6);
      psen_cnt = 0;
    end
  end

  task automatic issue(input logic [15:0] a);
    @(negedge clk); #1;
    req = 1'b1; req_addr = a;
    @(negedge clk); #1;
    req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset strobes", int'({ale, psen_n, ad_oe, done}), 4'b0100);
    #1 rst = 1'b0;
    run = 1'b1;
    idle(4);
    issue(16'h1234);
    idle(30);
    x2_mode = 1'b1;
    idle(4);
    issue(16'hABCD);
    idle(20);
    issue(16'h0F0F);
    idle(2);
    issue(16'h8001);
    issue(16'h7FFE);
    idle(30);
    x2_mode = 1'b0;
    idle(4);
    issue(16'hC3A5);
    idle(4);
    issue(16'h00FF);
    idle(40);
    issue(16'h5566);
    idle(4);
    x2_mode = 1'b1;
    idle(40);
    x2_mode = 1'b0;
    idle(4);
    issue(16'hFEDC);
    idle(2);
    issue(16'h1111);
    idle(3);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 abort strobes", int'({ale, psen_n, ad_oe, done}), 4'b0100);
    #1 rst = 1'b0;
    idle(30);
    chk("R10 held request dropped", int'(psen_n), 1);
    issue(16'h2468);
    idle(30);
    run = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule